// File: doc/BRIEF.md
# Infrared Carrier Modulation Transmitter

This block drives the single transmit pin of an infrared remote-control link. A free-running carrier counter, 8 bits wide by default, runs from zero up to a programmable period setting and then wraps, giving a carrier of period+1 clock cycles. The carrier is high while the counter is at or below a duty setting, so it starts every cycle high and its high time is duty+1 counts. A serial data bit, made by a separate data-timing engine, is ANDed with this carrier when modulation is on and passed straight through when it is off. A final polarity inversion follows, and the result is registered before it reaches the pin, so comparator ripple never shows on the pin.

The block also gathers two compare event pulses from the data-timing engine: one for the data compare and one for the period compare. Each is gated by its own enable bit. Any enabled event sets a sticky interrupt flag, which stays set until the clear input is pulsed. All inputs are plain levels or single-cycle pulses. The data bit is a sampled level, not a stream, so there is no valid/ready handshake and no back-pressure. Every setting may be changed on any cycle.

Top module: `ir_carrier_tx`

## Requirements
- R1: After reset, with all settings at zero, `tx_out` is 0, `irq` is 0 and the carrier counter is at 0.
- R2: With modulation on, the counter goes up by one each cycle. On the cycle after it is found at or above `period_cfg`, it is 0. This gives period+1 cycles per carrier cycle, and the counter wraps at once if the period is lowered below it.
- R3: While `carrier_en` is 0 the counter is held at 0. The first carrier cycle after enabling therefore begins with its high phase.
- R4: The carrier is high when the counter is less than or equal to `duty_cfg` and low otherwise. When `duty_cfg` is greater than or equal to `period_cfg`, the carrier is high for the whole cycle.
- R5: With `carrier_en` = 1, the value before inversion is `data_bit` AND carrier. A `data_bit` of 0 forces that value to 0.
- R6: With `carrier_en` = 0, the value before inversion is `data_bit` alone.
- R7: With `out_inv` = 1, `tx_out` is the complement of the value before inversion. With `out_inv` = 0, it is that value unchanged.
- R8: `tx_out` is registered. It shows the inputs and the counter value present before a rising clock edge, and it changes only at that edge.
- R9: `irq` is set on the edge after a cycle in which `evt_data_cmp` and `ie_data` are both 1, or `evt_period_cmp` and `ie_period` are both 1. An event whose enable bit is 0 leaves `irq` unchanged.
- R10: `irq` stays at 1 until a cycle with `irq_clear` = 1. If an enabled event arrives in the same cycle as the clear, the event wins and `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_cfg | input | 8 | Carrier period setting (cycle is period+1 counts) |
| duty_cfg | input | 8 | Carrier high-time setting (high for duty+1 counts) |
| carrier_en | input | 1 | 1 = modulate data with the carrier, 0 = data only |
| out_inv | input | 1 | 1 = invert the transmit pin |
| data_bit | input | 1 | Serial data level from the data-timing engine |
| evt_data_cmp | input | 1 | Data compare event pulse |
| evt_period_cmp | input | 1 | Period compare event pulse |
| ie_data | input | 1 | Enable for the data compare interrupt |
| ie_period | input | 1 | Enable for the period compare interrupt |
| irq_clear | input | 1 | Clears the sticky interrupt flag |
| tx_out | output | 1 | Registered transmit pin |
| irq | output | 1 | Sticky combined interrupt request |

## Verification
Two functions can meet in the same cycle: clearing the interrupt flag and the arrival of a new enabled compare event. The bench raises `irq_clear` and an enabled event on the same cycle while the flag is already set. It then requires `irq` to read 1 after the edge, because a new event must not be lost. A second collision is a period write below the running counter value. The bench lowers `period_cfg` mid-cycle and checks that the next sample shows the high phase of a fresh carrier cycle.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned N_IRQ     = 2;
  localparam int unsigned IRQ_DATA  = 0;
  localparam int unsigned IRQ_PER   = 1;
  typedef enum logic [1:0] {
    PATH_DATA_ONLY = 2'b00,
    PATH_MODULATED = 2'b01
  } path_e;
endpackage

// File: rtl/irtx_carrier_counter.sv
module irtx_carrier_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt
);
  logic at_end;
  assign at_end = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + W'(1);
  end

  // R2: step by one inside a cycle
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt < limit) |=> (cnt == W'($past(cnt) + W'(1))));
  // R2: wrap once at or above the period
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt >= limit) |=> (cnt == '0));
  // R3: held at zero while disabled
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt == '0));
endmodule

// File: rtl/irtx_carrier_shaper.sv
module irtx_carrier_shaper #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  output logic         carrier
);
  always_comb begin
    carrier = (cnt <= duty);
  end
endmodule

// File: rtl/irtx_out_stage.sv
module irtx_out_stage
  import ir_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data,
  input  logic carrier,
  input  logic mod_en,
  input  logic inv,
  output logic tx
);
  path_e path;
  logic  pre_inv;

  always_comb begin
    path    = mod_en ? PATH_MODULATED : PATH_DATA_ONLY;
    pre_inv = data;
    if (path == PATH_MODULATED) pre_inv = data & carrier;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx <= 1'b0;
    else        tx <= pre_inv ^ inv;
  end

  // R5: zero data forces the pin low when not inverted
  a_r5_data_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!data && !inv) |=> !tx);
  // R7: zero data gives a high pin when inverted
  a_r7_inv_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!data && inv) |=> tx);
  // R5: carrier low phase blanks the data
  a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !carrier) |=> (tx == $past(inv)));
endmodule

// File: rtl/irtx_irq_collect.sv
module irtx_irq_collect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ie,
  input  logic         clr,
  output logic         irq
);
  logic [N-1:0] gated;
  logic         hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = evt[i] & ie[i];
  end
  assign hit = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit | (irq & ~clr);
  end

  // R10: sticky without a clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  // R10: a clear with no enabled event drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (evt & ie) == '0) |=> !irq);
  // R9: masked or absent events cannot raise the flag
  a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (evt & ie) == '0) |=> !irq);
endmodule

// File: rtl/ir_carrier_tx.sv
module ir_carrier_tx
  import ir_tx_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] duty_cfg,
  input  logic             carrier_en,
  input  logic             out_inv,
  input  logic             data_bit,
  input  logic             evt_data_cmp,
  input  logic             evt_period_cmp,
  input  logic             ie_data,
  input  logic             ie_period,
  input  logic             irq_clear,
  output logic             tx_out,
  output logic             irq
);
  logic [CNT_W-1:0] car_cnt;
  logic             carrier;
  logic [N_IRQ-1:0] evt_vec;
  logic [N_IRQ-1:0] ie_vec;

  assign evt_vec[IRQ_DATA] = evt_data_cmp;
  assign evt_vec[IRQ_PER]  = evt_period_cmp;
  assign ie_vec[IRQ_DATA]  = ie_data;
  assign ie_vec[IRQ_PER]   = ie_period;

  irtx_carrier_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(carrier_en),
    .limit(period_cfg), .cnt(car_cnt)
  );

  irtx_carrier_shaper #(.W(CNT_W)) u_shape (
    .cnt(car_cnt), .duty(duty_cfg), .carrier(carrier)
  );

  irtx_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .data(data_bit), .carrier(carrier),
    .mod_en(carrier_en), .inv(out_inv), .tx(tx_out)
  );

  irtx_irq_collect #(.N(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .ie(ie_vec),
    .clr(irq_clear), .irq(irq)
  );

  // R4/R3: every carrier cycle opens with the high phase
  a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (car_cnt == '0) |-> carrier);
  // R4: a duty at or above the period keeps the carrier high inside the cycle
  a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_cfg >= period_cfg && car_cnt <= period_cfg) |-> carrier);
  // R6: no modulation means the pin follows data and polarity
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!carrier_en && data_bit && !out_inv) |=> tx_out);
endmodule

// File: tb/sim_ir_carrier_tx.sv
module sim_ir_carrier_tx;
  typedef struct packed {
    logic [7:0] per;
    logic [7:0] duty;
    logic       en;
    logic       inv;
    logic       data;
    logic [7:0] ncyc;
    logic [7:0] exp_hi;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'd3, 8'd1, 1'b1, 1'b0, 1'b1, 8'd8,  8'd4},   // R2 R4 R5
    '{8'd3, 8'd1, 1'b1, 1'b1, 1'b1, 8'd8,  8'd4},   // R7
    '{8'd4, 8'd7, 1'b1, 1'b0, 1'b1, 8'd10, 8'd10},  // R4 duty>period
    '{8'd0, 8'd0, 1'b1, 1'b0, 1'b1, 8'd6,  8'd6},   // R2 period 0
    '{8'd5, 8'd0, 1'b1, 1'b0, 1'b1, 8'd12, 8'd2},   // R4 narrow
    '{8'd3, 8'd1, 1'b1, 1'b0, 1'b0, 8'd8,  8'd0},   // R5 data 0
    '{8'd3, 8'd1, 1'b0, 1'b0, 1'b1, 8'd5,  8'd5},   // R6
    '{8'd3, 8'd1, 1'b0, 1'b1, 1'b0, 8'd5,  8'd5},   // R6 R7
    '{8'd2, 8'd2, 1'b1, 1'b0, 1'b1, 8'd6,  8'd6}    // R4 duty==period
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] period_cfg = '0, duty_cfg = '0;
  logic       carrier_en = 1'b0, out_inv = 1'b0, data_bit = 1'b0;
  logic       evt_data_cmp = 1'b0, evt_period_cmp = 1'b0;
  logic       ie_data = 1'b0, ie_period = 1'b0, irq_clear = 1'b0;
  logic       tx_out, irq;

  int n_chk = 0, n_bad = 0;
  int mcnt = 0;
  logic exp_tx = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ir_carrier_tx u0 (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .duty_cfg(duty_cfg),
    .carrier_en(carrier_en), .out_inv(out_inv), .data_bit(data_bit),
    .evt_data_cmp(evt_data_cmp), .evt_period_cmp(evt_period_cmp),
    .ie_data(ie_data), .ie_period(ie_period), .irq_clear(irq_clear),
    .tx_out(tx_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock edge with the bench's own carrier model; ends at the next negedge.
  task automatic step();
    @(posedge clk);
    exp_tx = (carrier_en ? (data_bit & (mcnt <= int'(duty_cfg))) : data_bit) ^ out_inv;
    if (!carrier_en)                mcnt = 0;
    else if (mcnt >= int'(period_cfg)) mcnt = 0;
    else                            mcnt = mcnt + 1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    chk("R1 tx reset", tx_out, 1'b0);
    chk("R1 irq reset", irq, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 tx idle after reset", tx_out, 1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      period_cfg = VEC[v].per; duty_cfg = VEC[v].duty;
      carrier_en = 1'b0; out_inv = 1'b0; data_bit = 1'b0;
      step();  // counter back to 0 (R3)
      carrier_en = VEC[v].en; out_inv = VEC[v].inv; data_bit = VEC[v].data;
      hi = 0;
      for (int c = 0; c < int'(VEC[v].ncyc); c++) begin
        step();
        chk($sformatf("R2/R4/R5/R6/R7 vec%0d cyc%0d", v, c), tx_out, exp_tx);
        if (tx_out === 1'b1) hi++;
      end
      n_chk++;
      if (hi != int'(VEC[v].exp_hi)) begin
        n_bad++;
        $display("FAIL R4 vec%0d high count: actual=%0d expected=%0d", v, hi, VEC[v].exp_hi);
      end
    end

    // R2: period lowered below the running counter wraps at once
    out_inv = 1'b0; data_bit = 1'b1; carrier_en = 1'b0;
    period_cfg = 8'd7; duty_cfg = 8'd3;
    step();
    carrier_en = 1'b1;
    repeat (5) step();          // counter now at 5
    period_cfg = 8'd2;
    step();                     // cnt 5 >= 2 -> 0 ; tx shows cnt 5 (low)
    chk("R2 tx before wrap", tx_out, 1'b0);
    step();                     // tx shows cnt 0
    chk("R2 wrap to high phase", tx_out, 1'b1);

    // R3: disable mid-cycle, then re-enable starts high
    period_cfg = 8'd5; duty_cfg = 8'd0;
    repeat (3) step();
    carrier_en = 1'b0;
    step();
    chk("R6 disabled passes data", tx_out, 1'b1);
    carrier_en = 1'b1;
    step();
    chk("R3 first cycle high", tx_out, 1'b1);
    step();
    chk("R3 then low phase", tx_out, 1'b0);

    // R8: registered output changes only at an edge
    carrier_en = 1'b0; data_bit = 1'b1;
    step();
    data_bit = 1'b0;
    #1;
    chk("R8 no change before edge", tx_out, 1'b1);
    step();
    chk("R8 change after edge", tx_out, 1'b0);

    // R9: masked event ignored
    evt_data_cmp = 1'b1; evt_period_cmp = 1'b1;
    step();
    evt_data_cmp = 1'b0; evt_period_cmp = 1'b0;
    chk("R9 masked events", irq, 1'b0);
    // R9: data compare enabled
    ie_data = 1'b1; evt_data_cmp = 1'b1;
    step();
    evt_data_cmp = 1'b0;
    chk("R9 data event sets", irq, 1'b1);
    repeat (3) step();
    chk("R10 sticky", irq, 1'b1);
    irq_clear = 1'b1;
    step();
    irq_clear = 1'b0;
    chk("R10 clear", irq, 1'b0);
    // R9: period compare source, its own enable
    ie_data = 1'b0; ie_period = 1'b1; evt_data_cmp = 1'b1;
    step();
    evt_data_cmp = 1'b0;
    chk("R9 data masked while period enabled", irq, 1'b0);
    evt_period_cmp = 1'b1;
    step();
    evt_period_cmp = 1'b0;
    chk("R9 period event sets", irq, 1'b1);
    // R10: clear and event collide -> stays set
    irq_clear = 1'b1; evt_period_cmp = 1'b1;
    step();
    irq_clear = 1'b0; evt_period_cmp = 1'b0;
    chk("R10 event beats clear", irq, 1'b1);
    irq_clear = 1'b1;
    step();
    irq_clear = 1'b0;
    chk("R10 clear after collision", irq, 1'b0);

    // R1: reset mid-operation
    carrier_en = 1'b1; data_bit = 1'b1; ie_data = 1'b1; evt_data_cmp = 1'b1;
    step();
    evt_data_cmp = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 async tx reset", tx_out, 1'b0);
    chk("R1 async irq reset", irq, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule